// File: doc/BRIEF.md
# I2C-Controlled 8-Bit GPIO Expander

This block is an eight-pin general-purpose I/O port that a host controls over an I2C target interface. The system clock oversamples SCL and SDA. Each line passes through a synchronizer and a stability filter, and a small bit engine then detects START and STOP, matches the target address, acknowledges bytes and shifts data in or out. The target address has a fixed four-bit prefix, chosen at build time by a parameter, and three low bits taken from strap inputs.

The first data byte of a write transfer sets a register pointer. Every later byte in that transfer goes to the register the pointer selects, and a read returns that same register for every byte. Four registers exist: the sampled pin levels (read-only), the output latch, a per-bit polarity inversion mask and a per-pin direction mask. Each pin has its own output enable, so a pin is driven only while its direction bit selects output.

Top module: `gpx_expander`

## Requirements
- R1: The 7-bit target address is the prefix (4'b0100 when VARIANT=0, 4'b0111 when VARIANT=1) followed by strap_i[2:0]. Bit 0 of the address byte is R/W, with 0 meaning write. The target drives SDA low in the ninth clock only when the address matches. On a mismatch it leaves SDA released for the rest of the transfer.
- R2: The first data byte after a write address loads the pointer from its two LSBs: 0 selects the input register, 1 the output register, 2 the polarity register and 3 the direction register. Each later byte in the same transfer is stored into the pointed register, and the pointer does not advance.
- R3: A read of register 0 returns each pin's present level XOR its polarity bit, whatever the pin's direction. Bit 7 is P7 and bit 0 is P0. The pins pass through a two-flop synchronizer, and the value is captured when each read byte is loaded.
- R4: A byte written to register 0 is acknowledged and leaves the output, polarity and direction registers unchanged.
- R5: The output register resets to 8'hFF. A read of it returns the last value written, not the pin level.
- R6: The polarity register resets to 8'h00. A 1 in bit n inverts bit n of the register 0 value, and a 0 leaves it as it is.
- R7: The direction register resets to 8'hFF. For a pin whose bit is 1, pin_oe is 0 and pin_o is 0, whatever its output-register bit holds. For a pin whose bit is 0, pin_oe is 1 and pin_o equals its output-register bit.
- R8: After a repeated START and a matching read address, every read byte returns the pointed register until the controller NACKs. After the NACK the target stops driving SDA.
- R9: A STOP or START at any point abandons the current byte without writing it and releases SDA. A START then begins a new address phase.
- R10: A level change on SCL or SDA is accepted only after FILT_LEN consecutive equal samples, so shorter pulses are ignored.
- R11: Data moves MSB first. Each received data byte is acknowledged. The target changes SDA only while the filtered SCL is low, except when it releases SDA on a START or a STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain drive) |
| strap_i | input | 3 | Low three address bits from strap pins |
| pin_i | input | PORT_W | Present level of each port pin |
| pin_o | output | PORT_W | Output value per pin |
| pin_oe | output | PORT_W | Driver enable per pin |

## Verification
The bench sends addresses that differ from the target address only in the prefix, and others that differ only in the strap bits. A decoder that ignored either field would acknowledge one of them. It reads register 0 with some pins driven, to catch a design that reports only the input pins, or that returns the latch instead of the pin level. It also changes the pins partway through a multi-byte read, to catch a design that captures the pins only once per transfer. Other cases are a write to register 0, which a careless write decoder would let corrupt a neighbouring register, and transfers cut short by a STOP or a repeated START in the middle of a byte, which would otherwise leave a half-shifted byte stored or the pointer lost. Finally, one-to-two-cycle glitches are placed on SDA while SCL is high and on SCL while it is low. A missing filter would turn these into a false START or an extra bit.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
   typedef enum logic [1:0] {
      REG_IN  = 2'd0,
      REG_OUT = 2'd1,
      REG_POL = 2'd2,
      REG_DIR = 2'd3
   } gpx_reg_e;

   typedef enum logic [2:0] {
      T_IDLE,
      T_ADDR,
      T_AACK,
      T_WDAT,
      T_WACK,
      T_RDAT,
      T_RACK
   } gpx_tgt_e;
endpackage

// File: rtl/gpx_line_filter.sv
module gpx_line_filter #(
   parameter int   SYNC_STAGES = 2,
   parameter int   FILT_LEN    = 3,
   parameter logic IDLE_LEVEL  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   output logic line_o
);
   logic [SYNC_STAGES-1:0] sync_q;
   logic [FILT_LEN-1:0]    hist_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= {SYNC_STAGES{IDLE_LEVEL}};
         hist_q <= {FILT_LEN{IDLE_LEVEL}};
         line_o <= IDLE_LEVEL;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
         hist_q <= {hist_q[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
         if (&hist_q)
            line_o <= 1'b1;
         else if (~|hist_q)
            line_o <= 1'b0;
      end
   end
endmodule

// File: rtl/gpx_i2c_target.sv
module gpx_i2c_target
   import gpx_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_f,
   input  logic              sda_f,
   input  logic [6:0]        my_addr,
   input  logic [BYTE_W-1:0] rd_data,
   output logic              sda_oe,
   output logic              wr_stb,
   output logic              wr_first,
   output logic [BYTE_W-1:0] wr_byte,
   output logic              start_det,
   output logic              stop_det
);
   localparam int CNT_W = $clog2(BYTE_W + 1);

   gpx_tgt_e          state_q;
   logic              scl_q, sda_q;
   logic [CNT_W-1:0]  bit_q;
   logic [BYTE_W-1:0] shift_q, tx_q;
   logic              rw_q, first_q, nack_q;
   logic              scl_rise, scl_fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_f;
         sda_q <= sda_f;
      end
   end

   assign scl_rise  = scl_f & ~scl_q;
   assign scl_fall  = ~scl_f & scl_q;
   assign start_det = scl_f & scl_q & sda_q & ~sda_f;
   assign stop_det  = scl_f & scl_q & ~sda_q & sda_f;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= T_IDLE;
         bit_q    <= '0;
         shift_q  <= '0;
         tx_q     <= '0;
         rw_q     <= 1'b0;
         first_q  <= 1'b0;
         nack_q   <= 1'b0;
         sda_oe   <= 1'b0;
         wr_stb   <= 1'b0;
         wr_first <= 1'b0;
         wr_byte  <= '0;
      end else begin
         wr_stb <= 1'b0;
         if (start_det) begin
            state_q <= T_ADDR;
            bit_q   <= '0;
            sda_oe  <= 1'b0;
         end else if (stop_det) begin
            state_q <= T_IDLE;
            sda_oe  <= 1'b0;
         end else if (scl_rise) begin
            case (state_q)
               T_ADDR, T_WDAT: begin
                  shift_q <= {shift_q[BYTE_W-2:0], sda_f};
                  bit_q   <= bit_q + 1'b1;
               end
               T_RDAT: bit_q  <= bit_q + 1'b1;
               T_RACK: nack_q <= sda_f;
               default: ;
            endcase
         end else if (scl_fall) begin
            case (state_q)
               T_ADDR: begin
                  if (bit_q == CNT_W'(BYTE_W)) begin
                     if (shift_q[7:1] == my_addr) begin
                        state_q <= T_AACK;
                        sda_oe  <= 1'b1;
                        rw_q    <= shift_q[0];
                     end else begin
                        state_q <= T_IDLE;
                     end
                  end
               end
               T_AACK: begin
                  bit_q <= '0;
                  if (rw_q) begin
                     state_q <= T_RDAT;
                     tx_q    <= rd_data;
                     sda_oe  <= ~rd_data[BYTE_W-1];
                  end else begin
                     state_q <= T_WDAT;
                     sda_oe  <= 1'b0;
                     first_q <= 1'b1;
                  end
               end
               T_WDAT: begin
                  if (bit_q == CNT_W'(BYTE_W)) begin
                     state_q  <= T_WACK;
                     sda_oe   <= 1'b1;
                     wr_stb   <= 1'b1;
                     wr_byte  <= shift_q;
                     wr_first <= first_q;
                     first_q  <= 1'b0;
                  end
               end
               T_WACK: begin
                  state_q <= T_WDAT;
                  sda_oe  <= 1'b0;
                  bit_q   <= '0;
               end
               T_RDAT: begin
                  if (bit_q == CNT_W'(BYTE_W)) begin
                     state_q <= T_RACK;
                     sda_oe  <= 1'b0;
                  end else begin
                     tx_q   <= {tx_q[BYTE_W-2:0], 1'b0};
                     sda_oe <= ~tx_q[BYTE_W-2];
                  end
               end
               T_RACK: begin
                  bit_q <= '0;
                  if (nack_q) begin
                     state_q <= T_IDLE;
                  end else begin
                     state_q <= T_RDAT;
                     tx_q    <= rd_data;
                     sda_oe  <= ~rd_data[BYTE_W-1];
                  end
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/gpx_regs.sv
module gpx_regs
   import gpx_pkg::*;
#(
   parameter int PORT_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_stb,
   input  logic              wr_first,
   input  logic [PORT_W-1:0] wr_byte,
   input  logic [PORT_W-1:0] pin_i,
   output logic [PORT_W-1:0] rd_data,
   output logic [PORT_W-1:0] pin_o,
   output logic [PORT_W-1:0] pin_oe,
   output gpx_reg_e          ptr_q,
   output logic [PORT_W-1:0] out_q,
   output logic [PORT_W-1:0] pol_q,
   output logic [PORT_W-1:0] cfg_q
);
   logic [SYNC_STAGES-1:0][PORT_W-1:0] psync_q;
   logic [PORT_W-1:0] pin_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) psync_q <= '0;
      else        psync_q <= {psync_q[SYNC_STAGES-2:0], pin_i};
   end
   assign pin_s = psync_q[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= REG_IN;
         out_q <= '1;
         pol_q <= '0;
         cfg_q <= '1;
      end else if (wr_stb) begin
         if (wr_first) begin
            ptr_q <= gpx_reg_e'(wr_byte[1:0]);
         end else begin
            case (ptr_q)
               REG_OUT: out_q <= wr_byte;
               REG_POL: pol_q <= wr_byte;
               REG_DIR: cfg_q <= wr_byte;
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      case (ptr_q)
         REG_IN:  rd_data = pin_s ^ pol_q;
         REG_OUT: rd_data = out_q;
         REG_POL: rd_data = pol_q;
         default: rd_data = cfg_q;
      endcase
   end

   for (genvar i = 0; i < PORT_W; i++) begin : g_pin
      assign pin_oe[i] = ~cfg_q[i];
      assign pin_o[i]  = cfg_q[i] ? 1'b0 : out_q[i];
   end
endmodule

// File: rtl/gpx_expander.sv
module gpx_expander
   import gpx_pkg::*;
#(
   parameter int VARIANT     = 0,
   parameter int PORT_W      = 8,
   parameter int FILT_LEN    = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe,
   input  logic [2:0]        strap_i,
   input  logic [PORT_W-1:0] pin_i,
   output logic [PORT_W-1:0] pin_o,
   output logic [PORT_W-1:0] pin_oe
);
   localparam int N_LINES = 2;

   if (PORT_W != 8) begin : g_bad_w
      $error("gpx_expander: PORT_W must be 8");
   end
   if (VARIANT != 0 && VARIANT != 1) begin : g_bad_v
      $error("gpx_expander: VARIANT must be 0 or 1");
   end
   if (FILT_LEN < 2 || SYNC_STAGES < 2) begin : g_bad_f
      $error("gpx_expander: FILT_LEN and SYNC_STAGES must be at least 2");
   end

   logic [3:0] prefix;
   if (VARIANT == 0) begin : g_pfx_a
      assign prefix = 4'b0100;
   end else begin : g_pfx_b
      assign prefix = 4'b0111;
   end

   logic [N_LINES-1:0] line_raw, line_f;
   logic scl_f, sda_f;
   assign line_raw = {sda_i, scl_i};
   for (genvar k = 0; k < N_LINES; k++) begin : g_filt
      gpx_line_filter #(
         .SYNC_STAGES (SYNC_STAGES),
         .FILT_LEN    (FILT_LEN),
         .IDLE_LEVEL  (1'b1)
      ) u_filt (
         .clk    (clk),
         .rst_n  (rst_n),
         .line_i (line_raw[k]),
         .line_o (line_f[k])
      );
   end
   assign scl_f = line_f[0];
   assign sda_f = line_f[1];

   logic              wr_stb, wr_first, start_det, stop_det;
   logic [PORT_W-1:0] wr_byte, rd_data, out_q, pol_q, cfg_q;
   gpx_reg_e          ptr_q;

   gpx_i2c_target #(.BYTE_W(PORT_W)) u_tgt (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_f     (scl_f),
      .sda_f     (sda_f),
      .my_addr   ({prefix, strap_i}),
      .rd_data   (rd_data),
      .sda_oe    (sda_oe),
      .wr_stb    (wr_stb),
      .wr_first  (wr_first),
      .wr_byte   (wr_byte),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   gpx_regs #(.PORT_W(PORT_W), .SYNC_STAGES(SYNC_STAGES)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_stb   (wr_stb),
      .wr_first (wr_first),
      .wr_byte  (wr_byte),
      .pin_i    (pin_i),
      .rd_data  (rd_data),
      .pin_o    (pin_o),
      .pin_oe   (pin_oe),
      .ptr_q    (ptr_q),
      .out_q    (out_q),
      .pol_q    (pol_q),
      .cfg_q    (cfg_q)
   );
endmodule

// File: rtl/gpx_expander_chk.sv
module gpx_expander_chk #(
   parameter int PORT_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              scl_f,
   input logic              sda_oe,
   input logic              start_det,
   input logic              stop_det,
   input logic              wr_stb,
   input logic              wr_first,
   input logic [PORT_W-1:0] wr_byte,
   input logic [1:0]        ptr_q,
   input logic [PORT_W-1:0] out_q,
   input logic [PORT_W-1:0] pol_q,
   input logic [PORT_W-1:0] cfg_q,
   input logic [PORT_W-1:0] pin_o,
   input logic [PORT_W-1:0] pin_oe
);
   // R7
   undriven_pin_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_o & ~pin_oe) == '0);

   // R9
   stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> !sda_oe);

   // R9
   start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> !sda_oe);

   // R4
   input_write_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && !wr_first && ptr_q == 2'd0)
      |=> ($stable(out_q) && $stable(pol_q) && $stable(cfg_q)));

   // R2
   pointer_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && wr_first)
      |=> (ptr_q == $past(wr_byte[1:0]) && $stable(out_q) && $stable(pol_q) && $stable(cfg_q)));

   // R11
   sda_change_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(sda_oe) && !$past(start_det) && !$past(stop_det)) |-> !scl_f);
endmodule

bind gpx_expander gpx_expander_chk #(.PORT_W(PORT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .scl_f     (scl_f),
   .sda_oe    (sda_oe),
   .start_det (start_det),
   .stop_det  (stop_det),
   .wr_stb    (wr_stb),
   .wr_first  (wr_first),
   .wr_byte   (wr_byte),
   .ptr_q     (ptr_q),
   .out_q     (out_q),
   .pol_q     (pol_q),
   .cfg_q     (cfg_q),
   .pin_o     (pin_o),
   .pin_oe    (pin_oe)
);

// File: tb/tb_gpx_expander.sv
`timescale 1ns/1ps
module tb_gpx_expander;
   localparam int QTR = 10;
   localparam logic [2:0] STRAP = 3'b101;
   localparam logic [6:0] ADDR  = {4'b0100, STRAP};
   localparam logic [7:0] AW = {ADDR, 1'b0};
   localparam logic [7:0] AR = {ADDR, 1'b1};

   logic clk = 1'b0, rst_n = 1'b0;
   logic scl_drv = 1'b1, sda_drv = 1'b1;
   logic [7:0] ext_pins = 8'h3C;
   logic sda_oe, sda_line;
   logic [7:0] pin_o, pin_oe, pad;
   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;
   assign sda_line = sda_drv & ~sda_oe;
   assign pad = (pin_oe & pin_o) | (~pin_oe & ext_pins);

   gpx_expander #(.VARIANT(0)) dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_drv), .sda_i(sda_line),
      .sda_oe(sda_oe), .strap_i(STRAP), .pin_i(pad),
      .pin_o(pin_o), .pin_oe(pin_oe)
   );

   task automatic waitn(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic send_bit(input logic b);
      waitn(QTR); sda_drv = b;
      waitn(QTR); scl_drv = 1'b1;
      waitn(2*QTR); scl_drv = 1'b0;
   endtask

   task automatic recv_bit(output logic b);
      waitn(QTR); sda_drv = 1'b1;
      waitn(QTR); scl_drv = 1'b1;
      waitn(QTR); b = sda_line;
      waitn(QTR); scl_drv = 1'b0;
   endtask

   task automatic i2c_start();
      sda_drv = 1'b1; waitn(QTR);
      scl_drv = 1'b1; waitn(QTR);
      sda_drv = 1'b0; waitn(QTR);
      scl_drv = 1'b0;
   endtask

   task automatic i2c_stop();
      waitn(QTR); sda_drv = 1'b0;
      waitn(QTR); scl_drv = 1'b1;
      waitn(QTR); sda_drv = 1'b1;
      waitn(QTR);
   endtask

   task automatic wr_byte(input logic [7:0] b, output logic ack);
      logic a;
      for (int i = 7; i >= 0; i--) send_bit(b[i]);
      recv_bit(a);
      ack = ~a;
   endtask

   task automatic rd_byte(input logic last, output logic [7:0] d);
      for (int i = 7; i >= 0; i--) recv_bit(d[i]);
      send_bit(last);
   endtask

   task automatic wr_reg(input logic [7:0] ptr, input logic [7:0] val, input string tag);
      logic a0, a1, a2;
      i2c_start();
      wr_byte(AW, a0); wr_byte(ptr, a1); wr_byte(val, a2);
      i2c_stop();
      chk({5'b0, a0, a1, a2}, 8'h07, tag);
   endtask

   task automatic rd_reg(input logic [7:0] ptr, output logic [7:0] d);
      logic a;
      i2c_start();
      wr_byte(AW, a); wr_byte(ptr, a);
      i2c_start();
      wr_byte(AR, a);
      rd_byte(1'b1, d);
      i2c_stop();
   endtask

   task automatic t_reset();
      logic [7:0] d;
      chk(pin_oe, 8'h00, "R7 pin_oe after reset");
      chk(pin_o, 8'h00, "R7 pin_o after reset");
      chk({7'b0, sda_oe}, 8'h00, "R9 sda released after reset");
      rd_reg(8'h01, d); chk(d, 8'hFF, "R5 output reg reset");
      rd_reg(8'h02, d); chk(d, 8'h00, "R6 polarity reg reset");
      rd_reg(8'h03, d); chk(d, 8'hFF, "R7 direction reg reset");
   endtask

   task automatic t_address();
      logic a;
      i2c_start(); wr_byte({4'b0111, STRAP, 1'b0}, a); i2c_stop();
      chk({7'b0, a}, 8'h00, "R1 wrong prefix not acked");
      i2c_start(); wr_byte({4'b0100, 3'b100, 1'b0}, a); i2c_stop();
      chk({7'b0, a}, 8'h00, "R1 wrong strap not acked");
      chk({7'b0, sda_oe}, 8'h00, "R1 SDA released after mismatch");
      i2c_start(); wr_byte(AW, a); i2c_stop();
      chk({7'b0, a}, 8'h01, "R1 matching address acked");
   endtask

   task automatic t_output();
      logic [7:0] d;
      wr_reg(8'h01, 8'hA5, "R11 acks on output write");
      wr_reg(8'h03, 8'h0F, "R2 acks on direction write");
      waitn(5);
      chk(pin_oe, 8'hF0, "R7 pin_oe from direction");
      chk(pin_o, 8'hA0, "R7 pin_o masked by direction");
      rd_reg(8'h01, d); chk(d, 8'hA5, "R5 output readback is latch");
      rd_reg(8'h00, d); chk(d, 8'hAC, "R3 input reg shows all pin levels");
   endtask

   task automatic t_polarity();
      logic [7:0] d;
      wr_reg(8'h02, 8'h0F, "R6 polarity write acked");
      rd_reg(8'h00, d); chk(d, 8'hA3, "R6 inverted input bits");
      wr_reg(8'h02, 8'h00, "R6 polarity clear acked");
      rd_reg(8'h00, d); chk(d, 8'hAC, "R6 original polarity");
   endtask

   task automatic t_input_write();
      logic [7:0] d;
      wr_reg(8'h00, 8'h55, "R4 input reg write acked");
      rd_reg(8'h01, d); chk(d, 8'hA5, "R4 output reg untouched");
      rd_reg(8'h02, d); chk(d, 8'h00, "R4 polarity reg untouched");
      rd_reg(8'h03, d); chk(d, 8'h0F, "R4 direction reg untouched");
      chk(pin_o, 8'hA0, "R4 pins untouched");
   endtask

   task automatic t_repeat_read();
      logic a;
      logic [7:0] d0, d1, d2;
      i2c_start(); wr_byte(AW, a); wr_byte(8'h01, a);
      i2c_start(); wr_byte(AR, a);
      rd_byte(1'b0, d0); rd_byte(1'b0, d1); rd_byte(1'b1, d2);
      waitn(QTR);
      chk({7'b0, sda_oe}, 8'h00, "R8 SDA released after NACK");
      i2c_stop();
      chk(d0, 8'hA5, "R8 read byte 1");
      chk(d1, 8'hA5, "R8 read byte 2 same register");
      chk(d2, 8'hA5, "R8 read byte 3 same register");
      i2c_start(); wr_byte(AW, a); wr_byte(8'h00, a);
      i2c_start(); wr_byte(AR, a);
      rd_byte(1'b0, d0);
      waitn(2*QTR); ext_pins = 8'h35;
      rd_byte(1'b0, d1); rd_byte(1'b1, d2);
      i2c_stop();
      chk(d0, 8'hAC, "R3 first captured byte");
      chk(d1, 8'hAC, "R3 byte loaded before pin change");
      chk(d2, 8'hA5, "R3 recaptured at next byte");
      ext_pins = 8'h3C;
   endtask

   task automatic t_abort();
      logic a;
      logic [7:0] d;
      i2c_start(); wr_byte(AW, a); wr_byte(8'h01, a);
      for (int i = 0; i < 4; i++) send_bit(1'b0);
      i2c_stop();
      chk({7'b0, sda_oe}, 8'h00, "R9 SDA released after STOP");
      rd_reg(8'h01, d); chk(d, 8'hA5, "R9 STOP mid-byte discards byte");
      i2c_start(); wr_byte(AW, a);
      send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
      i2c_start(); wr_byte(AR, a);
      chk({7'b0, a}, 8'h01, "R9 START restarts address phase");
      rd_byte(1'b1, d);
      i2c_stop();
      chk(d, 8'hA5, "R9 pointer kept after aborted byte");
   endtask

   task automatic send_bit_glitch(input logic b);
      waitn(8); scl_drv = 1'b1;
      waitn(2); scl_drv = 1'b0;
      waitn(2); sda_drv = b;
      waitn(8); scl_drv = 1'b1;
      waitn(QTR);
      if (b) begin sda_drv = 1'b0; waitn(1); sda_drv = 1'b1; end
      waitn(QTR - (b ? 1 : 0)); scl_drv = 1'b0;
   endtask

   task automatic t_glitch();
      logic a0, a1, a2, a;
      logic [7:0] d;
      logic [7:0] v = 8'h3C;
      i2c_start(); wr_byte(AW, a0); wr_byte(8'h01, a1);
      for (int i = 7; i >= 0; i--) send_bit_glitch(v[i]);
      recv_bit(a); a2 = ~a;
      i2c_stop();
      chk({5'b0, a0, a1, a2}, 8'h07, "R10 acks through glitches");
      rd_reg(8'h01, d); chk(d, 8'h3C, "R10 glitched byte stored intact");
      chk(pin_o, 8'h30, "R7 new outputs on output pins only");
   endtask

   initial begin
      waitn(5); rst_n = 1'b1; waitn(5);
      t_reset();
      t_address();
      t_output();
      t_polarity();
      t_input_write();
      t_repeat_read();
      t_abort();
      t_glitch();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule